// File: doc/BRIEF.md
# Sixteen-bit ALU with Condition Flags and Branch Evaluator

This block is the arithmetic core of a small multi-cycle processor datapath. Each clock it takes two word operands and an operation select. It computes a sum, a difference, a bitwise AND/OR/XOR, a shift or rotate whose kind comes from a four-bit mode field, or a signed comparison. The result is registered. A four-bit flag register sits beside the result register. It holds a two-bit relational code written only by the comparison, and an overflow bit and a carry bit written only by add, subtract and shift.

A branch-condition evaluator reads the registered flags and turns a four-bit condition selector into a taken signal. A sequencer can therefore decide a conditional branch in the cycle after the flag-setting operation. A flag-write enable lets the sequencer run an operation for its result alone and leave the flags as they were.

Top module: `alu_flagged`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0 and `flags` becomes 0.
- R2: `op_sel` = 0 (add) registers `opd_a + opd_b` mod 2^16 at the next edge. With `flag_we` high, flags[0] (C) takes the carry out and flags[1] (V) the signed two's-complement overflow.
- R3: `op_sel` = 1 (subtract) registers `opd_a - opd_b` mod 2^16. With `flag_we` high, C is 1 exactly when no borrow occurs (unsigned a >= b), and V is the signed overflow.
- R4: `op_sel` = 2, 3 and 4 register AND, OR and XOR of the operands.
- R5: `op_sel` = 5 shifts `opd_a` by the unsigned amount in `opd_b`. `shift_mode` bit0 = 1 selects right. Bit1 = 0 selects a plain shift, for which bit3 = 1 selects sign fill on a right shift. Amounts of 16 or more give all zeros, or all sign bits for a sign-filling shift. C takes the last bit shifted out (0 for amount 0), and V is cleared.
- R6: With `shift_mode` bit1 = 1 and bit2 = 0, the shift is a 16-bit rotate by the amount mod 16. C takes the last bit carried around: result bit 0 for left and bit 15 for right, and 0 when the amount is 0.
- R7: With `shift_mode` bits 1 and 2 both set, the rotate runs over a 17-bit ring with the current C flag as its top bit, by the amount mod 17. The new C is the ring's top bit afterwards.
- R8: `op_sel` = 6 (compare) writes flags[3:2] with 2'b10 when a < b (signed), 2'b01 when equal and 2'b00 when a > b. It registers a result of 0.
- R9: V and C change only on add, subtract and shift, and flags[3:2] change only on compare. AND, OR and XOR leave all four flags unchanged.
- R10: With `flag_we` low, `flags` holds its value, and `result` still updates.
- R11: `branch_taken` follows the registered flags without delay. `cond_sel` 0 = lt (code 10), 1 = eq (01), 2 = le (10 or 01), 3 = gt (00), 4 = V set, 5 = C set, 6 = V or C set, and 7..15 are never taken.
- R12: `op_sel` = 7 registers a result of 0 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opd_a | input | 16 | First operand; the value shifted |
| opd_b | input | 16 | Second operand; the shift amount |
| op_sel | input | 3 | Operation select |
| shift_mode | input | 4 | Direction, rotate, through-carry and sign-fill controls |
| flag_we | input | 1 | Allows the operation to update the flags |
| cond_sel | input | 4 | Branch condition selector |
| result | output | 16 | Registered result |
| flags | output | 4 | {relational code[1:0], V, C} |
| branch_taken | output | 1 | Selected condition holds on the current flags |

## Verification
The hardest case to reach from the ports is the 17-bit rotate through carry with a chosen carry-in. The carry is state left behind by an earlier operation, not an input. Before every through-carry rotate, the stimulus therefore runs an add that forces C to a known value (0+0 or 0xFFFF+1). It then sweeps all sixteen mode values over amounts 0 to 18 and several large amounts. The bench tracks the flag state in its own model across a long mixed stream of operations with random flag-write enables, so every condition code is also checked against the flags as they evolve.

// File: rtl/alu_flagged_pkg.sv
package alu_flagged_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHF = 3'd5,
    OP_CMP = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;

  // shift_mode bit positions
  localparam int SM_RIGHT = 0;
  localparam int SM_ROT   = 1;
  localparam int SM_THRU  = 2;
  localparam int SM_ARITH = 3;

  // relational codes
  localparam logic [1:0] REL_LT = 2'b10;
  localparam logic [1:0] REL_EQ = 2'b01;
  localparam logic [1:0] REL_GT = 2'b00;

  // condition selectors
  localparam logic [3:0] CC_LT = 4'd0;
  localparam logic [3:0] CC_EQ = 4'd1;
  localparam logic [3:0] CC_LE = 4'd2;
  localparam logic [3:0] CC_GT = 4'd3;
  localparam logic [3:0] CC_V  = 4'd4;
  localparam logic [3:0] CC_C  = 4'd5;
  localparam logic [3:0] CC_VC = 4'd6;

  typedef struct packed {
    logic [1:0] rel;
    logic       v;
    logic       c;
  } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;

  assign b_eff = sub ? ~b : b;
  assign ext   = {1'b0, a} + {1'b0, b_eff} + (W+1)'(sub);
  assign sum   = ext[W-1:0];
  assign carry = ext[W];
  // signed overflow: operands (as added) agree in sign, result differs
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_flagged_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] amt,
  input  logic [3:0]   mode,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam logic [W-1:0] WV  = W'(W);
  localparam logic [W-1:0] W1V = W'(W + 1);

  logic [W:0]        sl, sr;
  logic signed [W:0] sa;
  logic [W-1:0]      rot_n, ring_n;
  logic [W-1:0]      rl, rr;
  logic [W:0]        ring, tl, tr;

  // plain shifts, one extra bit catches the last bit shifted out
  assign sl = {1'b0, a} << amt;
  assign sr = {a, 1'b0} >> amt;
  assign sa = $signed({a, 1'b0}) >>> amt;

  // rotate within the word
  assign rot_n = amt % WV;
  assign rl    = (a << rot_n) | (a >> (WV - rot_n));
  assign rr    = (a >> rot_n) | (a << (WV - rot_n));

  // rotate through the carry bit
  assign ring   = {cin, a};
  assign ring_n = amt % W1V;
  assign tl     = (ring << ring_n) | (ring >> (W1V - ring_n));
  assign tr     = (ring >> ring_n) | (ring << (W1V - ring_n));

  always_comb begin
    res  = a;
    cout = 1'b0;
    if (mode[SM_ROT]) begin
      if (mode[SM_THRU]) begin
        res  = mode[SM_RIGHT] ? tr[W-1:0] : tl[W-1:0];
        cout = mode[SM_RIGHT] ? tr[W] : tl[W];
      end else begin
        res  = mode[SM_RIGHT] ? rr : rl;
        cout = (amt == '0) ? 1'b0 : (mode[SM_RIGHT] ? rr[W-1] : rl[0]);
      end
    end else if (mode[SM_RIGHT]) begin
      if (mode[SM_ARITH]) begin
        res  = sa[W:1];
        cout = sa[0];
      end else begin
        res  = sr[W:1];
        cout = sr[0];
      end
    end else begin
      res  = sl[W-1:0];
      cout = sl[W];
    end
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare
  import alu_flagged_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [1:0]   rel
);
  always_comb begin
    if ($signed(a) < $signed(b))      rel = REL_LT;
    else if (a == b)                  rel = REL_EQ;
    else                              rel = REL_GT;
  end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_flagged_pkg::*;
(
  input  flags_t     fl,
  input  logic [3:0] cond,
  output logic       taken
);
  always_comb begin
    case (cond)
      CC_LT:   taken = (fl.rel == REL_LT);
      CC_EQ:   taken = (fl.rel == REL_EQ);
      CC_LE:   taken = (fl.rel == REL_LT) || (fl.rel == REL_EQ);
      CC_GT:   taken = (fl.rel == REL_GT);
      CC_V:    taken = fl.v;
      CC_C:    taken = fl.c;
      CC_VC:   taken = fl.v | fl.c;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_flagged_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic [2:0]   op_sel,
  input  logic [3:0]   shift_mode,
  input  logic         flag_we,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] result,
  output logic [3:0]   flags,
  output logic         branch_taken
);
  alu_op_e      op;
  flags_t       fl_q, fl_d;
  logic [W-1:0] res_d;
  logic [W-1:0] as_sum, sh_res;
  logic         as_c, as_v, sh_c;
  logic [1:0]   cmp_rel;

  assign op = alu_op_e'(op_sel);

  alu_addsub #(.W(W)) u_addsub (
    .a(opd_a), .b(opd_b), .sub(op == OP_SUB),
    .sum(as_sum), .carry(as_c), .ovf(as_v)
  );

  alu_shifter #(.W(W)) u_shift (
    .a(opd_a), .amt(opd_b), .mode(shift_mode), .cin(fl_q.c),
    .res(sh_res), .cout(sh_c)
  );

  alu_compare #(.W(W)) u_cmp (
    .a(opd_a), .b(opd_b), .rel(cmp_rel)
  );

  always_comb begin
    res_d = '0;
    fl_d  = fl_q;
    case (op)
      OP_ADD, OP_SUB: begin
        res_d = as_sum;
        fl_d.v = as_v;
        fl_d.c = as_c;
      end
      OP_AND: res_d = opd_a & opd_b;
      OP_OR:  res_d = opd_a | opd_b;
      OP_XOR: res_d = opd_a ^ opd_b;
      OP_SHF: begin
        res_d = sh_res;
        fl_d.v = 1'b0;
        fl_d.c = sh_c;
      end
      OP_CMP: fl_d.rel = cmp_rel;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fl_q   <= '0;
    end else begin
      result <= res_d;
      if (flag_we) fl_q <= fl_d;
    end
  end

  assign flags = fl_q;

  alu_cond_eval u_cond (
    .fl(fl_q), .cond(cond_sel), .taken(branch_taken)
  );
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_sel,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic [3:0]   flags
);
  AST_FLAGS_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags)); // R10

  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd2 || op_sel == 3'd3 || op_sel == 3'd4) |=> $stable(flags)); // R9

  AST_CMP_KEEPS_VC: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd6) |=> $stable(flags[1:0])); // R8

  AST_ARITH_KEEPS_REL: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd5) |=> $stable(flags[3:2])); // R9

  AST_SHIFT_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd5 && flag_we) |=> !flags[1]); // R5

  AST_CMP_RESULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd6) |=> (result == '0)); // R8

  AST_NOP_RESULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd7) |=> (result == '0 && $stable(flags))); // R12

  AST_REL_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    flags[3:2] != 2'b11); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && flags == 4'd0)); // R1
endmodule

bind alu_flagged alu_flagged_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .flag_we(flag_we),
  .result(result), .flags(flags)
);

// File: tb/tb_alu_flagged.sv
`timescale 1ns/1ps
module tb_alu_flagged;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opd_a = '0, opd_b = '0;
  logic [2:0]  op_sel = '0;
  logic [3:0]  shift_mode = '0;
  logic        flag_we = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic [15:0] result;
  logic [3:0]  flags;
  logic        branch_taken;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_flags = 4'd0;   // bench model of the flag register
  int cc_idx = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  alu_flagged dut (
    .clk(clk), .rst(rst), .opd_a(opd_a), .opd_b(opd_b), .op_sel(op_sel),
    .shift_mode(shift_mode), .flag_we(flag_we), .cond_sel(cond_sel),
    .result(result), .flags(flags), .branch_taken(branch_taken)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_taken(input logic [3:0] f, input logic [3:0] c);
    logic [1:0] rel;
    rel = f[3:2];
    case (c)
      4'd0: return rel == 2'b10;
      4'd1: return rel == 2'b01;
      4'd2: return rel == 2'b10 || rel == 2'b01;
      4'd3: return rel == 2'b00;
      4'd4: return f[1];
      4'd5: return f[0];
      4'd6: return f[1] | f[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op, input logic [3:0] m);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3, 3'd4: return "R4";
      3'd5: return m[1] ? (m[2] ? "R7" : "R6") : "R5";
      3'd6: return "R8";
      default: return "R12";
    endcase
  endfunction

  // independent model: one bit at a time for shifts, integers for arithmetic
  task automatic model(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] op, input logic [3:0] m,
                       output logic [15:0] r, output logic [3:0] nf);
    int sa, n;
    logic c, nb;
    nf = m_flags;
    r  = '0;
    case (op)
      3'd0: begin
        r = a + b;
        sa = $signed(a) + $signed(b);
        nf[0] = (int'(a) + int'(b)) > 65535;
        nf[1] = (sa > 32767) || (sa < -32768);
      end
      3'd1: begin
        r = a - b;
        sa = $signed(a) - $signed(b);
        nf[0] = (a >= b);
        nf[1] = (sa > 32767) || (sa < -32768);
      end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: begin
        r = a;
        if (m[1] && m[2]) begin
          c = m_flags[0];
          n = int'(b) % 17;
          for (int i = 0; i < n; i++) begin
            if (!m[0]) begin nb = r[15]; r = {r[14:0], c}; end
            else       begin nb = r[0];  r = {c, r[15:1]}; end
            c = nb;
          end
        end else if (m[1]) begin
          c = 1'b0;
          n = int'(b) % 16;
          for (int i = 0; i < n; i++) begin
            if (!m[0]) begin nb = r[15]; r = {r[14:0], nb}; end
            else       begin nb = r[0];  r = {nb, r[15:1]}; end
            c = nb;
          end
          if (b != 0 && n == 0) c = m[0] ? a[15] : a[0];
        end else begin
          c = 1'b0;
          n = (b > 17) ? 17 : int'(b);
          for (int i = 0; i < n; i++) begin
            if (!m[0]) begin c = r[15]; r = {r[14:0], 1'b0}; end
            else begin c = r[0]; r = {(m[3] ? r[15] : 1'b0), r[15:1]}; end
          end
        end
        nf[0] = c;
        nf[1] = 1'b0;
      end
      3'd6: begin
        if ($signed(a) < $signed(b)) nf[3:2] = 2'b10;
        else if (a == b)             nf[3:2] = 2'b01;
        else                         nf[3:2] = 2'b00;
      end
      default: r = '0;
    endcase
  endtask

  // called just after a falling edge
  task automatic do_op(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] op, input logic [3:0] m, input logic we);
    logic [15:0] er;
    logic [3:0]  ef;
    opd_a = a; opd_b = b; op_sel = op; shift_mode = m; flag_we = we;
    cond_sel = 4'(cc_idx % 16);
    cc_idx++;
    #1;
    check("R11", "branch_taken", 16'(branch_taken), 16'(exp_taken(m_flags, cond_sel)));
    model(a, b, op, m, er, ef);
    @(posedge clk);
    @(negedge clk);
    check(op_tag(op, m), "result", result, er);
    if (we) begin
      check((op >= 3'd2 && op <= 3'd4) ? "R9" : op_tag(op, m), "flags", 16'(flags), 16'(ef));
      m_flags = ef;
    end else begin
      check("R10", "flags", 16'(flags), 16'(m_flags));
    end
  endtask

  function automatic logic [31:0] step_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  logic [15:0] vals [14] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                             16'h8001, 16'hFFFF, 16'hFFFE, 16'h00FF, 16'hFF00,
                             16'h5555, 16'hAAAA, 16'h1234, 16'h7FFE};
  logic [15:0] samt [23] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6,
                             16'd7, 16'd8, 16'd9, 16'd10, 16'd11, 16'd12,
                             16'd13, 16'd14, 16'd15, 16'd16, 16'd17, 16'd18,
                             16'd31, 16'd34, 16'd255, 16'hFFFF};
  logic [15:0] spat [4] = '{16'h8001, 16'hB3C5, 16'h7F0E, 16'hFFFF};

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset, with garbage on the inputs
    opd_a = 16'hFFFF; opd_b = 16'h0001; op_sel = 3'd0; flag_we = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset result", result, 16'h0000);
    check("R1", "reset flags", 16'(flags), 16'h0000);
    rst = 1'b0;
    m_flags = 4'd0;

    // arithmetic and compare over corner values
    for (int op = 0; op < 7; op++) begin
      if (op == 5) continue;
      for (int i = 0; i < 14; i++)
        for (int j = 0; j < 14; j++)
          do_op(vals[i], vals[j], 3'(op), 4'd0, 1'b1);
    end

    // all shift modes and amounts, both carry-in values (R5 R6 R7)
    for (int cin = 0; cin < 2; cin++)
      for (int md = 0; md < 16; md++)
        for (int k = 0; k < 23; k++)
          for (int p = 0; p < 4; p++) begin
            do_op(cin != 0 ? 16'hFFFF : 16'h0000, cin != 0 ? 16'h0001 : 16'h0000,
                  3'd0, 4'd0, 1'b1);
            do_op(spat[p], samt[k], 3'd5, 4'(md), 1'b1);
          end

    // set up a known relational code, then ops with flag writes disabled (R10)
    do_op(16'h0003, 16'h0009, 3'd6, 4'd0, 1'b1);
    for (int op = 0; op < 8; op++)
      do_op(16'h8000, 16'h8000, 3'(op), 4'd3, 1'b0);

    // op 7 (R12)
    do_op(16'h1111, 16'h2222, 3'd7, 4'd0, 1'b1);

    // long mixed stream, random flag-write enables
    for (int n = 0; n < 6000; n++) begin
      logic [15:0] ra, rb;
      rng = step_rng(rng); ra = rng[15:0]; rb = rng[31:16];
      rng = step_rng(rng);
      if (rng[3:0] < 4'd5) rb = {11'd0, rng[8:4]};
      do_op(ra, rb, rng[18:16], rng[23:20], rng[24] | rng[25]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule